// File: doc/BRIEF.md
# Floating-Point Load/Store Pair Sequencer

This block sits between a floating-point register file and a simple 64-bit memory request port. It accepts one load or store command at a time and forms the effective address from a base value plus either a sign-extended displacement or an index value. It then runs the memory transfers: one transfer for an ordinary access, two consecutive 64-bit transfers for a register-pair access. For update forms it writes the effective address back to the base general register. A one-cycle `done` pulse ends every command.

Single-precision data goes through a lightweight format stage. Loads widen a 32-bit word into the 64-bit register format by placing its bits. Stores narrow the register by selecting bits. Word-integer loads sign-extend or zero-extend a 32-bit word. Pair transfers move an even/odd register pair. The `le_mode` input chooses which register of the pair goes to the lower address. Byte order inside a 64-bit word is left to the memory port. A command is refused when the floating-point enable is low, and an update form that names base register 0 is refused as invalid. A refused command touches neither memory nor any register.

Top module: `fpls_seq`

## Requirements
- R1: The effective address is `cmd_base + sext(cmd_disp)` when `cmd_use_index`=0, and `cmd_base + cmd_index` when it is 1. A non-pair access issues exactly one memory transfer at that address.
- R2: A pair access (`cmd_pair`=1) issues two 64-bit transfers (`mem_dw`=1), the first at EA and the second at EA+8.
- R3: With `le_mode`=0, a pair access uses register `cmd_rt` for the transfer at EA and `cmd_rt`+1 for the transfer at EA+8.
- R4: With `le_mode`=1, a pair access uses register `cmd_rt`+1 for the transfer at EA and `cmd_rt` for the transfer at EA+8.
- R5: For an update form (`cmd_update`=1) that is accepted, `gpr_we` pulses once with `gpr_wr_addr`=`cmd_ra` and `gpr_wr_data`=EA, in the cycle after the last acknowledged transfer, and `done` follows in the next cycle.
- R6: An update form with `cmd_ra`=0 and the enable high ends with `done` and `invalid` both high in the cycle after acceptance. It makes no memory request, no FPR write and no GPR write.
- R7: A command accepted while `fp_enable`=0 ends with `done` and `unavailable` both high in the cycle after acceptance, with no request and no register write. This takes priority over R6, so `invalid` stays low.
- R8: A single load (kind 1) makes a 32-bit transfer (`mem_dw`=0) and reads `mem_rdata[31:0]`. A word w with w[30:0]≠0 is written as sign w[31], 11-bit exponent w[30:23]+896, fraction {w[22:0], 29 zeros}. A word with w[30:0]=0 is written as a zero of sign w[31].
- R9: A single store (kind 5) makes a 32-bit transfer with `mem_wdata` = {32'b0, d[63], d[62], d[58:29]}, where d is the source register.
- R10: A word load with sign extension (kind 2) or zero extension (kind 3) makes a 32-bit transfer and writes `mem_rdata[31:0]` extended to 64 bits. A word store (kind 6) writes {32'b0, d[31:0]}.
- R11: `mem_req` and its address, direction and size stay stable until `mem_ack`. For an accepted command with w wait cycles per transfer, `done` is high for exactly one cycle: cycle beats·(w+1)+U+1 after acceptance, where U is 1 for update forms and 0 otherwise.
- R12: `cmd_kind` codes: 0 double load, 1 single load, 2 word load sign-extended, 3 word load zero-extended, 4 double store, 5 single store, 6 word store, 7 double store. Kinds 0, 4 and 7 use 64-bit transfers of the raw register value, and loads write that register on the acknowledged cycle.
- R13: A command is accepted only on a clock edge where `cmd_valid`=1 and `busy`=0. `busy` stays high from acceptance until the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_kind | input | 3 | Transfer kind code (R12) |
| cmd_pair | input | 1 | Register-pair access |
| cmd_update | input | 1 | Write EA back to base register |
| cmd_use_index | input | 1 | Select the index value instead of the displacement |
| le_mode | input | 1 | Little-endian pair ordering |
| cmd_rt | input | 5 | Target or source FP register |
| cmd_ra | input | 5 | Base register number |
| cmd_base | input | AW | Base register contents |
| cmd_index | input | AW | Index register contents |
| cmd_disp | input | DISP_W | Signed displacement |
| fp_enable | input | 1 | Floating-point unit enabled |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_dw | output | 1 | 1 for a 64-bit transfer, 0 for a 32-bit one |
| mem_addr | output | AW | Request address |
| mem_wdata | output | 64 | Write data (32-bit data in the low half) |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| fpr_rd_addr | output | 5 | FP register read address |
| fpr_rd_data | input | 64 | FP register read data (combinational) |
| fpr_we | output | 1 | FP register write |
| fpr_wr_addr | output | 5 | FP register write address |
| fpr_wr_data | output | 64 | FP register write data |
| gpr_we | output | 1 | Base register write |
| gpr_wr_addr | output | 5 | Base register number |
| gpr_wr_data | output | AW | Updated base value (EA) |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | With `done`: update form refused for base 0 |
| unavailable | output | 1 | With `done`: refused because the enable was low |

## Verification
Refused commands are due one cycle after acceptance. Each memory transfer finishes on the cycle its acknowledge is sampled, and an FP register load write lands in that same cycle. The base-register write comes one cycle after the last transfer, and `done` comes one cycle after that. The bench holds its own memory image and register file, queues the expected transfers and writes when a command is issued, and compares them on every clock at a point half a cycle after the edge. It also counts the cycles since acceptance and checks that `done` appears in exactly the cycle the latency formula gives for the chosen wait count. Any request or register write that arrives with an empty expectation queue fails, which covers the cases that must have no effect.

// File: rtl/fpls_pkg.sv
package fpls_pkg;

    localparam int REG_W = 5;
    localparam int FP_W  = 64;
    localparam int SP_W  = 32;
    localparam int SP_EXP_TOP = 30;

    typedef enum logic [2:0] {
        K_LD_DBL = 3'd0,
        K_LD_SGL = 3'd1,
        K_LD_WSX = 3'd2,
        K_LD_WZX = 3'd3,
        K_ST_DBL = 3'd4,
        K_ST_SGL = 3'd5,
        K_ST_WRD = 3'd6,
        K_ST_ALT = 3'd7
    } xfer_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC0,
        ST_ACC1,
        ST_WBACK,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        xfer_kind_e       kind;
        logic             pair;
        logic             update;
        logic             swap;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] ra;
    } xfer_op_t;

    function automatic logic kind_is_store(xfer_kind_e k);
        return (k inside {K_ST_DBL, K_ST_SGL, K_ST_WRD, K_ST_ALT});
    endfunction

    function automatic logic kind_is_dword(xfer_kind_e k, logic pair);
        return pair || (k inside {K_LD_DBL, K_ST_DBL, K_ST_ALT});
    endfunction

    // Bit placement only: normal values and signed zero map exactly.
    function automatic logic [FP_W-1:0] widen_single(logic [SP_W-1:0] w);
        if (w[SP_EXP_TOP:0] == '0)
            return {w[SP_W-1], {(FP_W-1){1'b0}}};
        return {w[31], w[30], {3{~w[30]}}, w[29:0], 29'd0};
    endfunction

    function automatic logic [SP_W-1:0] narrow_double(logic [FP_W-1:0] d);
        return {d[63:62], d[58:29]};
    endfunction

    // Register used by a beat: the odd partner goes first when swapped.
    function automatic logic [REG_W-1:0] beat_reg(logic [REG_W-1:0] rt,
                                                  logic swap, logic second);
        return (second ^ swap) ? rt + REG_W'(1) : rt;
    endfunction

endpackage

// File: rtl/fpls_agen.sv
module fpls_agen #(
    parameter int AW     = 64,
    parameter int DISP_W = 16
) (
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     index,
    input  logic [DISP_W-1:0] disp,
    input  logic              use_index,
    input  logic [AW-1:0]     ea_hold,
    input  logic              second,
    output logic [AW-1:0]     ea_new,
    output logic [AW-1:0]     beat_addr
);
    localparam int BEAT_BYTES = 8;
    localparam int EXT_W      = AW - DISP_W;

    logic [AW-1:0] offset;

    always_comb begin
        offset    = use_index ? index : {{EXT_W{disp[DISP_W-1]}}, disp};
        ea_new    = base + offset;
        beat_addr = ea_hold + (second ? AW'(BEAT_BYTES) : '0);
    end
endmodule

// File: rtl/fpls_fmt.sv
module fpls_fmt
    import fpls_pkg::*;
(
    input  xfer_kind_e      kind,
    input  logic            pair,
    input  logic [FP_W-1:0] rd_mem,
    input  logic [FP_W-1:0] rd_fpr,
    output logic [FP_W-1:0] load_val,
    output logic [FP_W-1:0] store_val,
    output logic            dword
);
    localparam int PAD_W = FP_W - SP_W;

    logic [SP_W-1:0] mem_lo;
    assign mem_lo = rd_mem[SP_W-1:0];

    always_comb begin
        dword = kind_is_dword(kind, pair);
        if (dword) begin
            load_val = rd_mem;
        end else begin
            case (kind)
                K_LD_SGL: load_val = widen_single(mem_lo);
                K_LD_WSX: load_val = {{PAD_W{mem_lo[SP_W-1]}}, mem_lo};
                default:  load_val = {{PAD_W{1'b0}}, mem_lo};
            endcase
        end
        if (dword) begin
            store_val = rd_fpr;
        end else if (kind == K_ST_SGL) begin
            store_val = {{PAD_W{1'b0}}, narrow_double(rd_fpr)};
        end else begin
            store_val = {{PAD_W{1'b0}}, rd_fpr[SP_W-1:0]};
        end
    end
endmodule

// File: rtl/fpls_ctrl.sv
module fpls_ctrl
    import fpls_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic       fp_enable,
    input  logic       cmd_update,
    input  logic       cmd_base_zero,
    input  logic       op_pair,
    input  logic       op_update,
    input  logic       mem_ack,
    output seq_state_e state,
    output logic       launch,
    output logic       rej_inval,
    output logic       rej_unav
);
    logic take;
    logic bad_base;

    assign take     = (state == ST_IDLE) && cmd_valid;
    assign bad_base = cmd_update && cmd_base_zero;
    assign launch   = take && fp_enable && !bad_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rej_inval <= 1'b0;
            rej_unav  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        rej_unav  <= !fp_enable;
                        rej_inval <= fp_enable && bad_base;
                        state     <= launch ? ST_ACC0 : ST_DONE;
                    end
                end
                ST_ACC0: begin
                    if (mem_ack) begin
                        if (op_pair)        state <= ST_ACC1;
                        else if (op_update) state <= ST_WBACK;
                        else                state <= ST_DONE;
                    end
                end
                ST_ACC1: begin
                    if (mem_ack) state <= op_update ? ST_WBACK : ST_DONE;
                end
                ST_WBACK: state <= ST_DONE;
                default: begin
                    state     <= ST_IDLE;
                    rej_inval <= 1'b0;
                    rej_unav  <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/fpls_seq.sv
module fpls_seq
    import fpls_pkg::*;
#(
    parameter int AW     = 64,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_kind,
    input  logic              cmd_pair,
    input  logic              cmd_update,
    input  logic              cmd_use_index,
    input  logic              le_mode,
    input  logic [REG_W-1:0]  cmd_rt,
    input  logic [REG_W-1:0]  cmd_ra,
    input  logic [AW-1:0]     cmd_base,
    input  logic [AW-1:0]     cmd_index,
    input  logic [DISP_W-1:0] cmd_disp,
    input  logic              fp_enable,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_dw,
    output logic [AW-1:0]     mem_addr,
    output logic [FP_W-1:0]   mem_wdata,
    input  logic              mem_ack,
    input  logic [FP_W-1:0]   mem_rdata,
    output logic [REG_W-1:0]  fpr_rd_addr,
    input  logic [FP_W-1:0]   fpr_rd_data,
    output logic              fpr_we,
    output logic [REG_W-1:0]  fpr_wr_addr,
    output logic [FP_W-1:0]   fpr_wr_data,
    output logic              gpr_we,
    output logic [REG_W-1:0]  gpr_wr_addr,
    output logic [AW-1:0]     gpr_wr_data,
    output logic              done,
    output logic              invalid,
    output logic              unavailable
);
    seq_state_e       state;
    logic             launch;
    logic             rej_inval;
    logic             rej_unav;
    xfer_op_t         op_q;
    logic [AW-1:0]    ea_q;
    logic [AW-1:0]    ea_new;
    logic [AW-1:0]    beat_addr;
    logic             second;
    logic             xfer_on;
    logic [REG_W-1:0] cur_reg;
    logic [FP_W-1:0]  load_val;
    logic [FP_W-1:0]  store_val;
    logic             dword;

    fpls_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .fp_enable     (fp_enable),
        .cmd_update    (cmd_update),
        .cmd_base_zero (cmd_ra == '0),
        .op_pair       (op_q.pair),
        .op_update     (op_q.update),
        .mem_ack       (mem_ack),
        .state         (state),
        .launch        (launch),
        .rej_inval     (rej_inval),
        .rej_unav      (rej_unav)
    );

    fpls_agen #(.AW(AW), .DISP_W(DISP_W)) u_agen (
        .base      (cmd_base),
        .index     (cmd_index),
        .disp      (cmd_disp),
        .use_index (cmd_use_index),
        .ea_hold   (ea_q),
        .second    (second),
        .ea_new    (ea_new),
        .beat_addr (beat_addr)
    );

    fpls_fmt u_fmt (
        .kind      (op_q.kind),
        .pair      (op_q.pair),
        .rd_mem    (mem_rdata),
        .rd_fpr    (fpr_rd_data),
        .load_val  (load_val),
        .store_val (store_val),
        .dword     (dword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
            ea_q <= '0;
        end else if (launch) begin
            op_q.kind   <= xfer_kind_e'(cmd_kind);
            op_q.pair   <= cmd_pair;
            op_q.update <= cmd_update;
            op_q.swap   <= cmd_pair & le_mode;
            op_q.rt     <= cmd_rt;
            op_q.ra     <= cmd_ra;
            ea_q        <= ea_new;
        end
    end

    assign second  = (state == ST_ACC1);
    assign xfer_on = (state == ST_ACC0) || second;
    assign cur_reg = beat_reg(op_q.rt, op_q.swap, second);

    assign busy      = (state != ST_IDLE);
    assign mem_req   = xfer_on;
    assign mem_we    = kind_is_store(op_q.kind);
    assign mem_dw    = dword;
    assign mem_addr  = beat_addr;
    assign mem_wdata = store_val;

    assign fpr_rd_addr = cur_reg;
    assign fpr_we      = xfer_on && mem_ack && !kind_is_store(op_q.kind);
    assign fpr_wr_addr = cur_reg;
    assign fpr_wr_data = load_val;

    assign gpr_we      = (state == ST_WBACK);
    assign gpr_wr_addr = op_q.ra;
    assign gpr_wr_data = ea_q;

    assign done        = (state == ST_DONE);
    assign invalid     = done && rej_inval;
    assign unavailable = done && rej_unav;
endmodule

// File: rtl/fpls_seq_chk.sv
module fpls_seq_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic          mem_dw,
    input logic [AW-1:0] mem_addr,
    input logic          fpr_we,
    input logic          gpr_we,
    input logic [4:0]    gpr_wr_addr,
    input logic          done,
    input logic          invalid,
    input logic          unavailable
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_dw)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_load_on_ack_R12: assert property (@(posedge clk) disable iff (rst)
        fpr_we |-> (mem_req && mem_ack && !mem_we));

    assert_no_base0_write_R6: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> (gpr_wr_addr != 5'd0));

    assert_wb_then_done_R5: assert property (@(posedge clk) disable iff (rst)
        gpr_we |=> done);

    assert_refuse_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (invalid || unavailable) |-> (done && !(invalid && unavailable) && !$past(mem_req) && !fpr_we && !gpr_we));

    assert_busy_after_done_R13: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
endmodule

bind fpls_seq fpls_seq_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_we      (mem_we),
    .mem_dw      (mem_dw),
    .mem_addr    (mem_addr),
    .fpr_we      (fpr_we),
    .gpr_we      (gpr_we),
    .gpr_wr_addr (gpr_wr_addr),
    .done        (done),
    .invalid     (invalid),
    .unavailable (unavailable)
);

// File: tb/fpls_seq_tb_top.sv
module fpls_seq_tb_top;
    localparam int AW = 64;
    localparam int DW = 16;

    localparam logic [2:0] C_LDD = 3'd0, C_LDS = 3'd1, C_LWS = 3'd2, C_LWZ = 3'd3;
    localparam logic [2:0] C_STD = 3'd4, C_STS = 3'd5, C_STW = 3'd6, C_STA = 3'd7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic          cmd_valid, cmd_pair, cmd_update, cmd_use_index, le_mode, fp_enable;
    logic [2:0]    cmd_kind;
    logic [4:0]    cmd_rt, cmd_ra;
    logic [AW-1:0] cmd_base, cmd_index;
    logic [DW-1:0] cmd_disp;
    logic          busy, mem_req, mem_we, mem_dw, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata, mem_rdata;
    logic [4:0]    fpr_rd_addr, fpr_wr_addr, gpr_wr_addr;
    logic [63:0]   fpr_rd_data, fpr_wr_data;
    logic [AW-1:0] gpr_wr_data;
    logic          fpr_we, gpr_we, done, invalid, unavailable;

    fpls_seq #(.AW(AW), .DISP_W(DW)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_pair(cmd_pair), .cmd_update(cmd_update), .cmd_use_index(cmd_use_index),
        .le_mode(le_mode), .cmd_rt(cmd_rt), .cmd_ra(cmd_ra), .cmd_base(cmd_base),
        .cmd_index(cmd_index), .cmd_disp(cmd_disp), .fp_enable(fp_enable),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_dw(mem_dw),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .fpr_rd_addr(fpr_rd_addr), .fpr_rd_data(fpr_rd_data),
        .fpr_we(fpr_we), .fpr_wr_addr(fpr_wr_addr), .fpr_wr_data(fpr_wr_data),
        .gpr_we(gpr_we), .gpr_wr_addr(gpr_wr_addr), .gpr_wr_data(gpr_wr_data),
        .done(done), .invalid(invalid), .unavailable(unavailable)
    );

    logic [63:0] fregs [32];
    assign fpr_rd_data = fregs[fpr_rd_addr];

    typedef struct packed { logic [63:0] addr; logic we; logic dw; logic [63:0] wdata; } mem_exp_t;
    typedef struct packed { logic [4:0] idx; logic [63:0] val; } reg_exp_t;

    mem_exp_t q_mem[$];
    reg_exp_t q_fpr[$];
    reg_exp_t q_gpr[$];
    logic [63:0] spec_mem [logic [63:0]];

    int    n_chk = 0, n_fail = 0;
    int    wait_cfg = 0, wcnt = 0, cyc = 0, exp_cyc = 0;
    bit    exp_inv, exp_unav, done_seen;
    string cur_req = "R13";

    function automatic logic [63:0] mem_at(logic [63:0] a);
        if (spec_mem.exists(a)) return spec_mem[a];
        return {~a[31:0] ^ 32'h0F0F_0000, 32'h3F80_0000 | {12'd0, a[19:0]}};
    endfunction

    function automatic logic [63:0] to_double(logic [31:0] w);
        logic [10:0] e;
        if (w[30:0] == 31'd0) return {w[31], 63'd0};
        e = 11'(w[30:23]) + 11'd896;
        return {w[31], e, w[22:0], 29'd0};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Memory responder and per-clock comparison, half a cycle after each edge.
    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (!rst && mem_req) begin
            if (wcnt >= wait_cfg) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_at(mem_addr);
                wcnt      = 0;
            end else begin
                wcnt++;
            end
        end
        #1;
        if (!rst) begin
            if (cmd_valid) cyc = 0; else cyc++;
            if (mem_req && mem_ack) begin
                if (q_mem.size() == 0) begin
                    chk(0, cur_req, "unexpected memory transfer", mem_addr, 64'd0);
                end else begin
                    mem_exp_t e;
                    e = q_mem.pop_front();
                    chk(mem_addr == e.addr, cur_req, "address", mem_addr, e.addr);
                    chk(mem_we == e.we, cur_req, "direction", 64'(mem_we), 64'(e.we));
                    chk(mem_dw == e.dw, cur_req, "size", 64'(mem_dw), 64'(e.dw));
                    if (e.we) chk(mem_wdata == e.wdata, cur_req, "store data", mem_wdata, e.wdata);
                end
            end
            if (fpr_we) begin
                if (q_fpr.size() == 0) begin
                    chk(0, cur_req, "unexpected fpr write", 64'(fpr_wr_addr), 64'd0);
                end else begin
                    reg_exp_t e;
                    e = q_fpr.pop_front();
                    chk(fpr_wr_addr == e.idx, cur_req, "fpr index", 64'(fpr_wr_addr), 64'(e.idx));
                    chk(fpr_wr_data == e.val, cur_req, "fpr data", fpr_wr_data, e.val);
                    fregs[e.idx] = e.val;
                end
            end
            if (gpr_we) begin
                if (q_gpr.size() == 0) begin
                    chk(0, cur_req, "unexpected gpr write", 64'(gpr_wr_addr), 64'd0);
                end else begin
                    reg_exp_t e;
                    e = q_gpr.pop_front();
                    chk(gpr_wr_addr == e.idx, "R5", "base index", 64'(gpr_wr_addr), 64'(e.idx));
                    chk(gpr_wr_data == e.val, "R5", "base value", gpr_wr_data, e.val);
                end
            end
            if (done) begin
                chk(cyc == exp_cyc, "R11", "done cycle", 64'(cyc), 64'(exp_cyc));
                chk(invalid == exp_inv, "R6", "invalid flag", 64'(invalid), 64'(exp_inv));
                chk(unavailable == exp_unav, "R7", "unavailable flag", 64'(unavailable), 64'(exp_unav));
                done_seen = 1'b1;
            end
        end
    end

    task automatic run_op(string req, logic [2:0] kind, bit pair, bit upd, bit idx, bit le,
                          logic [4:0] rt, logic [4:0] ra, logic [63:0] base,
                          logic [63:0] index, logic [15:0] disp, bit fen, int wt);
        logic [63:0] ea;
        int beats;
        bit st, dw;
        ea    = idx ? base + index : base + {{48{disp[15]}}, disp};
        st    = kind[2];
        beats = pair ? 2 : 1;
        dw    = pair || kind == C_LDD || kind == C_STD || kind == C_STA;
        exp_unav = !fen;
        exp_inv  = fen && upd && (ra == 5'd0);
        if (!exp_unav && !exp_inv) begin
            for (int b = 0; b < beats; b++) begin
                logic [4:0]  r;
                logic [63:0] a, w, v;
                a = ea + 64'(8 * b);
                r = (!pair || ((b == 0) != le)) ? rt : rt + 5'd1;
                if (st) begin
                    v = dw ? fregs[r] :
                        (kind == C_STS) ? {32'd0, fregs[r][63], fregs[r][62], fregs[r][58:29]} :
                        {32'd0, fregs[r][31:0]};
                    q_mem.push_back('{addr: a, we: 1'b1, dw: dw, wdata: v});
                end else begin
                    w = mem_at(a);
                    v = dw ? w : (kind == C_LDS) ? to_double(w[31:0]) :
                        (kind == C_LWS) ? {{32{w[31]}}, w[31:0]} : {32'd0, w[31:0]};
                    q_mem.push_back('{addr: a, we: 1'b0, dw: dw, wdata: 64'd0});
                    q_fpr.push_back('{idx: r, val: v});
                end
            end
            if (upd) q_gpr.push_back('{idx: ra, val: ea});
            exp_cyc = beats * (wt + 1) + (upd ? 1 : 0) + 1;
        end else begin
            exp_cyc = 1;
        end
        @(negedge clk);
        cur_req   = req;
        wait_cfg  = wt;
        wcnt      = 0;
        done_seen = 1'b0;
        chk(!busy, "R13", "idle before issue", 64'(busy), 64'd0);
        cmd_kind = kind; cmd_pair = pair; cmd_update = upd; cmd_use_index = idx;
        le_mode = le; cmd_rt = rt; cmd_ra = ra; cmd_base = base; cmd_index = index;
        cmd_disp = disp; fp_enable = fen; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 200 && !done_seen; i++) @(negedge clk);
        chk(done_seen, req, "completion seen", 64'(done_seen), 64'd1);
        chk(q_mem.size() == 0, req, "pending transfers", 64'(q_mem.size()), 64'd0);
        chk(q_fpr.size() == 0, req, "pending fpr writes", 64'(q_fpr.size()), 64'd0);
        chk(q_gpr.size() == 0, req, "pending gpr writes", 64'(q_gpr.size()), 64'd0);
        q_mem.delete(); q_fpr.delete(); q_gpr.delete();
        @(negedge clk);
        chk(!busy && !done, "R13", "idle after done", {62'd0, busy, done}, 64'd0);
    endtask

    initial begin
        #1200000;
        n_fail++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_up();
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < 32; i++)
            fregs[i] = {16'h4010 + 16'(i), 16'hBEEF, 32'h1357_9BDF ^ 32'(i)};
        spec_mem[64'h2000] = {32'hDEAD_BEEF, 32'h8000_0000};
        spec_mem[64'h2008] = {32'h0000_0000, 32'hC120_0000};
        spec_mem[64'h2010] = {32'h0000_0001, 32'hFFFF_FF85};
        rst = 1'b1; cmd_valid = 1'b0; cmd_kind = 3'd0; cmd_pair = 1'b0; cmd_update = 1'b0;
        cmd_use_index = 1'b0; le_mode = 1'b0; cmd_rt = 5'd0; cmd_ra = 5'd0;
        cmd_base = '0; cmd_index = '0; cmd_disp = '0; fp_enable = 1'b1;
        mem_ack = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        chk({busy, mem_req, done, fpr_we, gpr_we} == 5'd0, "R13", "reset state",
            64'({busy, mem_req, done, fpr_we, gpr_we}), 64'd0);

        run_op("R1",  C_LDD, 0, 0, 0, 0,  5'd4,  5'd7, 64'h1000, 64'h0,   16'h0040, 1, 0);
        run_op("R1",  C_LDD, 0, 0, 1, 0,  5'd5,  5'd8, 64'h1000, 64'h238, 16'h0,    1, 2);
        run_op("R1",  C_STD, 0, 0, 0, 0,  5'd6,  5'd9, 64'h1100, 64'h0,   16'hFFF0, 1, 1);
        run_op("R8",  C_LDS, 0, 0, 0, 0,  5'd10, 5'd2, 64'h2000, 64'h0,   16'h0,    1, 0);
        run_op("R8",  C_LDS, 0, 1, 0, 0,  5'd11, 5'd3, 64'h2000, 64'h0,   16'h0008, 1, 1);
        run_op("R8",  C_LDS, 0, 0, 0, 0,  5'd12, 5'd3, 64'h3000, 64'h0,   16'h0124, 1, 0);
        run_op("R9",  C_STS, 0, 0, 0, 0,  5'd12, 5'd3, 64'h3000, 64'h0,   16'h0200, 1, 0);
        run_op("R9",  C_STS, 0, 0, 0, 0,  5'd2,  5'd3, 64'h3000, 64'h0,   16'h0204, 1, 2);
        run_op("R10", C_LWS, 0, 0, 0, 0,  5'd13, 5'd1, 64'h2010, 64'h0,   16'h0,    1, 0);
        run_op("R10", C_LWZ, 0, 0, 0, 0,  5'd14, 5'd1, 64'h2010, 64'h0,   16'h0,    1, 1);
        run_op("R10", C_STW, 0, 0, 0, 0,  5'd15, 5'd1, 64'h2400, 64'h0,   16'h0010, 1, 0);
        run_op("R3",  C_LDD, 1, 0, 0, 0,  5'd16, 5'd5, 64'h4000, 64'h0,   16'h0,    1, 1);
        run_op("R4",  C_LDD, 1, 0, 0, 1,  5'd18, 5'd5, 64'h4000, 64'h0,   16'h0,    1, 0);
        run_op("R3",  C_STD, 1, 0, 0, 0,  5'd20, 5'd5, 64'h5000, 64'h0,   16'h0020, 1, 0);
        run_op("R4",  C_STD, 1, 1, 1, 1,  5'd22, 5'd4, 64'h5000, 64'h40,  16'h0,    1, 2);
        run_op("R2",  C_LDD, 1, 1, 0, 0,  5'd24, 5'd6, 64'h6000, 64'h0,   16'hFFF8, 1, 0);
        run_op("R6",  C_LDD, 0, 1, 0, 0,  5'd3,  5'd0, 64'h7000, 64'h0,   16'h0,    1, 0);
        run_op("R6",  C_STD, 1, 1, 1, 0,  5'd8,  5'd0, 64'h7000, 64'h8,   16'h0,    1, 1);
        run_op("R7",  C_LDD, 0, 0, 0, 0,  5'd3,  5'd2, 64'h7000, 64'h0,   16'h0,    0, 0);
        run_op("R7",  C_STS, 0, 1, 0, 0,  5'd3,  5'd0, 64'h7000, 64'h0,   16'h0,    0, 0);
        run_op("R12", C_STA, 0, 0, 0, 0,  5'd7,  5'd2, 64'h7100, 64'h0,   16'h0008, 1, 1);
        run_op("R5",  C_STD, 0, 1, 1, 0,  5'd9,  5'd31, 64'h7200, 64'h18, 16'h0,    1, 0);

        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 24; n++) begin
            logic [2:0] k;
            bit p, u;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            k = lfsr[30:28];
            p = lfsr[27] && (k == C_LDD || k == C_STD);
            u = lfsr[26];
            run_op("R11", k, p, u, lfsr[25], lfsr[24], {lfsr[20:17], 1'b0},
                   {1'b0, lfsr[16:13]} + 5'd1, 64'h8000 + 64'(lfsr[11:4]) * 64'd8,
                   64'(lfsr[9:6]) * 64'd16, {8'd0, lfsr[7:3], 3'd0}, 1, int'(lfsr[2:1]));
        end
        finish_up();
    end
endmodule